// File: doc/BRIEF.md
# Byte-Lane Dual-Port RAM

This block is a synchronous 2048 x 16 storage array with two equal and fully independent access ports, called left and right. Every clock edge, each port can read, write or do nothing at any address. Both ports may also use the same word in the same cycle. Every control input is active low. Each port has the following controls:

- a select;
- a read enable;
- one write strobe for the upper byte and one for the lower byte;
- a hold input that blocks the port's writes.

The ports split the 16-bit word into two byte lanes, upper and lower, and control each lane on its own. One access on a port can write one lane and return the other lane. Read data is registered and appears on the output one clock after the access.

Each lane has a valid flag that takes the place of a high-impedance output. When a lane's flag is low, that lane's data bits read as zero.

An external arbiter can drive a port's hold input low to block that port's writes. Reads on that port carry on as normal while hold is low. This block does no arbitration itself. If both ports write the same byte of the same word in one cycle, the right port's data is kept.

Top module: `dpr_byte_lane_ram`

## Requirements
- R1: After reset, both valid bits of both ports are 0 and both read data buses are all zero. Whenever a lane's valid bit is 0, that lane's eight data bits are zero. Valid bit 1 and data bits 15:8 belong to the upper lane. Valid bit 0 and data bits 7:0 belong to the lower lane.
- R2: When a port's select is high at an edge, the port writes nothing. Its valid bits are 00 after that edge, whatever the other controls are.
- R3: When a port is selected with both write strobes low, both bytes are written (hold high). The read enable is ignored, and the valid bits are 00 after the edge.
- R4: When a port is selected with exactly one write strobe low and read enable low, the strobed byte is written. The other lane returns the stored byte (before this edge) with only its valid bit set: 01 when the upper lane is written, 10 when the lower lane is written.
- R5: When a port is selected with exactly one write strobe low and read enable high, only the strobed byte changes, and the valid bits are 00.
- R6: When a port is selected with no write strobe low, the result depends on read enable. With read enable low, the valid bits are 11 and both bytes of the addressed word are returned. With read enable high, the valid bits are 00.
- R7: While a port's hold input is low, none of its writes changes the memory. Its read lanes behave as in R4 and R6.
- R8: Read data for an access at edge N is on the output from just after edge N until edge N+1.
- R9: If both ports write the same byte of the same word at one edge, the right port's byte is stored. Writes to different bytes of the same word at one edge both take effect.
- R10: A read of a word that the other port writes at the same edge returns the old contents. A read at the next edge returns the new contents.
- R11: Both ports reading the same word at the same edge, with neither writing, return identical data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| l_sel_n | input | 1 | Left port select, active low |
| l_oe_n | input | 1 | Left read enable, active low |
| l_wr_hi_n | input | 1 | Left upper-byte write strobe, active low |
| l_wr_lo_n | input | 1 | Left lower-byte write strobe, active low |
| l_hold_n | input | 1 | Left write block, active low |
| l_addr | input | 11 | Left word address |
| l_wdata | input | 16 | Left write data |
| l_rdata | output | 16 | Left read data, zero in invalid lanes |
| l_rvalid | output | 2 | Left lane valid flags {upper, lower} |
| r_sel_n | input | 1 | Right port select, active low |
| r_oe_n | input | 1 | Right read enable, active low |
| r_wr_hi_n | input | 1 | Right upper-byte write strobe, active low |
| r_wr_lo_n | input | 1 | Right lower-byte write strobe, active low |
| r_hold_n | input | 1 | Right write block, active low |
| r_addr | input | 11 | Right word address |
| r_wdata | input | 16 | Right write data |
| r_rdata | output | 16 | Right read data, zero in invalid lanes |
| r_rvalid | output | 2 | Right lane valid flags {upper, lower} |

## Verification
Two cases need the same word on both ports at one edge. In the first, the left port writes a word while the right port writes the same word. The bench drives both ports in the same cycle, with full-word writes and then with writes to different lanes. A later read must show the right port's byte in any lane both ports wrote, and both bytes when the lanes differ. In the second case, one port writes a word while the other port reads it. The read must return the old word, and a read one edge later must return the new word.

// File: rtl/dpr_pkg.sv
package dpr_pkg;

  // Number of byte lanes per word: index 1 is the upper lane, index 0 the lower lane.
  localparam int LANES = 2;

  typedef struct packed {
    logic [LANES-1:0] wbe;  // per-lane write enable, after the hold gate
    logic [LANES-1:0] rde;  // per-lane read enable
  } lane_ctl_t;

  // Turns the active-low port controls into per-lane write and read enables.
  // A lane is written when its strobe is low and hold is high.
  // A lane is read when read enable is low and its strobe is high.
  function automatic lane_ctl_t decode_lanes(
    input logic             sel_n,
    input logic             oe_n,
    input logic [LANES-1:0] wr_n,
    input logic             hold_n
  );
    lane_ctl_t c;
    for (int b = 0; b < LANES; b++) begin
      c.wbe[b] = !sel_n && !wr_n[b] && hold_n;
      c.rde[b] = !sel_n && !oe_n && wr_n[b];
    end
    return c;
  endfunction

endpackage

// File: rtl/dpr_lane_decode.sv
module dpr_lane_decode
  import dpr_pkg::*;
(
  input  logic             sel_n,
  input  logic             oe_n,
  input  logic [LANES-1:0] wr_n,
  input  logic             hold_n,
  output logic [LANES-1:0] wbe,
  output logic [LANES-1:0] rde
);

  lane_ctl_t ctl;

  always_comb begin
    ctl = decode_lanes(sel_n, oe_n, wr_n, hold_n);
    wbe = ctl.wbe;
    rde = ctl.rde;
  end

endmodule

// File: rtl/dpr_mem_array.sv
module dpr_mem_array
  import dpr_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int LANE_W = 8
) (
  input  logic                               clk,
  input  logic [1:0][ADDR_W-1:0]             addr,
  input  logic [1:0][LANES*LANE_W-1:0]       wdata,
  input  logic [1:0][LANES-1:0]              wbe,
  output logic [1:0][LANES*LANE_W-1:0]       rword
);

  localparam int DATA_W = LANES * LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // The port loop runs left (0) then right (1), so the right port's byte
  // overrides the left port's when both write the same byte.
  // The reads take the value held before this edge.
  always_ff @(posedge clk) begin
    for (int p = 0; p < 2; p++) begin
      for (int b = 0; b < LANES; b++) begin
        if (wbe[p][b]) mem[addr[p]][b*LANE_W +: LANE_W] <= wdata[p][b*LANE_W +: LANE_W];
      end
    end
    for (int p = 0; p < 2; p++) begin
      rword[p] <= mem[addr[p]];
    end
  end

endmodule

// File: rtl/dpr_read_stage.sv
module dpr_read_stage
  import dpr_pkg::*;
#(
  parameter int LANE_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [LANES-1:0]          rde,
  input  logic [LANES*LANE_W-1:0]   rword,
  output logic [LANES*LANE_W-1:0]   rdata,
  output logic [LANES-1:0]          rvalid
);

  logic [LANES-1:0] rde_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rde_q <= '0;
    else        rde_q <= rde;
  end

  assign rvalid = rde_q;

  // A lane that was not read shows zero in place of high impedance.
  always_comb begin
    for (int b = 0; b < LANES; b++) begin
      rdata[b*LANE_W +: LANE_W] = rde_q[b] ? rword[b*LANE_W +: LANE_W] : '0;
    end
  end

endmodule

// File: rtl/dpr_byte_lane_ram.sv
module dpr_byte_lane_ram
  import dpr_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    l_sel_n,
  input  logic                    l_oe_n,
  input  logic                    l_wr_hi_n,
  input  logic                    l_wr_lo_n,
  input  logic                    l_hold_n,
  input  logic [ADDR_W-1:0]       l_addr,
  input  logic [2*LANE_W-1:0]     l_wdata,
  output logic [2*LANE_W-1:0]     l_rdata,
  output logic [1:0]              l_rvalid,
  input  logic                    r_sel_n,
  input  logic                    r_oe_n,
  input  logic                    r_wr_hi_n,
  input  logic                    r_wr_lo_n,
  input  logic                    r_hold_n,
  input  logic [ADDR_W-1:0]       r_addr,
  input  logic [2*LANE_W-1:0]     r_wdata,
  output logic [2*LANE_W-1:0]     r_rdata,
  output logic [1:0]              r_rvalid
);

  localparam int DATA_W = LANES * LANE_W;

  // Port-indexed bundles: index 0 is left, index 1 is right.
  logic [1:0]              sel_n_a, oe_n_a, hold_n_a;
  logic [1:0][LANES-1:0]   wr_n_a, wbe_a, rde_a, rvalid_a;
  logic [1:0][ADDR_W-1:0]  addr_a;
  logic [1:0][DATA_W-1:0]  wdata_a, rword_a, rdata_a;

  // Named internal events for the checker.
  logic [LANES-1:0] l_wbe, r_wbe;

  assign sel_n_a  = {r_sel_n, l_sel_n};
  assign oe_n_a   = {r_oe_n, l_oe_n};
  assign hold_n_a = {r_hold_n, l_hold_n};
  assign wr_n_a   = {{r_wr_hi_n, r_wr_lo_n}, {l_wr_hi_n, l_wr_lo_n}};
  assign addr_a   = {r_addr, l_addr};
  assign wdata_a  = {r_wdata, l_wdata};

  for (genvar p = 0; p < 2; p++) begin : g_port
    dpr_lane_decode u_dec (
      .sel_n  (sel_n_a[p]),
      .oe_n   (oe_n_a[p]),
      .wr_n   (wr_n_a[p]),
      .hold_n (hold_n_a[p]),
      .wbe    (wbe_a[p]),
      .rde    (rde_a[p])
    );

    dpr_read_stage #(.LANE_W(LANE_W)) u_rd (
      .clk    (clk),
      .rst_n  (rst_n),
      .rde    (rde_a[p]),
      .rword  (rword_a[p]),
      .rdata  (rdata_a[p]),
      .rvalid (rvalid_a[p])
    );
  end

  dpr_mem_array #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_mem (
    .clk   (clk),
    .addr  (addr_a),
    .wdata (wdata_a),
    .wbe   (wbe_a),
    .rword (rword_a)
  );

  assign l_wbe    = wbe_a[0];
  assign r_wbe    = wbe_a[1];
  assign l_rdata  = rdata_a[0];
  assign l_rvalid = rvalid_a[0];
  assign r_rdata  = rdata_a[1];
  assign r_rvalid = rvalid_a[1];

endmodule

// File: rtl/dpr_byte_lane_ram_chk.sv
module dpr_byte_lane_ram_chk #(
  parameter int ADDR_W = 11,
  parameter int LANE_W = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                l_sel_n,
  input logic                l_oe_n,
  input logic                l_wr_hi_n,
  input logic                l_wr_lo_n,
  input logic                l_hold_n,
  input logic [ADDR_W-1:0]   l_addr,
  input logic [2*LANE_W-1:0] l_rdata,
  input logic [1:0]          l_rvalid,
  input logic [1:0]          l_wbe,
  input logic                r_sel_n,
  input logic                r_oe_n,
  input logic                r_wr_hi_n,
  input logic                r_wr_lo_n,
  input logic                r_hold_n,
  input logic [ADDR_W-1:0]   r_addr,
  input logic [2*LANE_W-1:0] r_rdata,
  input logic [1:0]          r_rvalid,
  input logic [1:0]          r_wbe
);

  // R1
  l_lane_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (l_rvalid == 2'b00) |-> (l_rdata == '0));
  // R1
  r_lane_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (r_rvalid == 2'b00) |-> (r_rdata == '0));

  // R2
  l_desel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    l_sel_n |=> (l_rvalid == 2'b00));
  // R2
  r_desel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    r_sel_n |=> (r_rvalid == 2'b00));

  // R3
  l_full_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!l_sel_n && !l_wr_hi_n && !l_wr_lo_n) |=> (l_rvalid == 2'b00));

  // R4
  l_mixed_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!l_sel_n && !l_oe_n && !l_wr_hi_n && l_wr_lo_n) |=> (l_rvalid == 2'b01));
  // R4
  r_mixed_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!r_sel_n && !r_oe_n && r_wr_hi_n && !r_wr_lo_n) |=> (r_rvalid == 2'b10));

  // R5
  l_no_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    l_oe_n |=> (l_rvalid == 2'b00));

  // R6
  l_full_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!l_sel_n && !l_oe_n && l_wr_hi_n && l_wr_lo_n) |=> (l_rvalid == 2'b11));

  // R7
  l_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !l_hold_n |-> (l_wbe == 2'b00));
  // R7
  r_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !r_hold_n |-> (r_wbe == 2'b00));

  // R11
  same_word_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!l_sel_n && !r_sel_n && !l_oe_n && !r_oe_n && l_wr_hi_n && l_wr_lo_n &&
     r_wr_hi_n && r_wr_lo_n && (l_addr == r_addr)) |=> (l_rdata == r_rdata));

endmodule

bind dpr_byte_lane_ram dpr_byte_lane_ram_chk #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .l_sel_n   (l_sel_n),
  .l_oe_n    (l_oe_n),
  .l_wr_hi_n (l_wr_hi_n),
  .l_wr_lo_n (l_wr_lo_n),
  .l_hold_n  (l_hold_n),
  .l_addr    (l_addr),
  .l_rdata   (l_rdata),
  .l_rvalid  (l_rvalid),
  .l_wbe     (l_wbe),
  .r_sel_n   (r_sel_n),
  .r_oe_n    (r_oe_n),
  .r_wr_hi_n (r_wr_hi_n),
  .r_wr_lo_n (r_wr_lo_n),
  .r_hold_n  (r_hold_n),
  .r_addr    (r_addr),
  .r_rdata   (r_rdata),
  .r_rvalid  (r_rvalid),
  .r_wbe     (r_wbe)
);

// File: tb/test_dpr_byte_lane_ram.sv
`timescale 1ns/1ps
module test_dpr_byte_lane_ram;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        l_sel_n = 1'b1, l_oe_n = 1'b1, l_wr_hi_n = 1'b1, l_wr_lo_n = 1'b1, l_hold_n = 1'b1;
  logic [10:0] l_addr = '0;
  logic [15:0] l_wdata = '0;
  logic [15:0] l_rdata;
  logic [1:0]  l_rvalid;
  logic        r_sel_n = 1'b1, r_oe_n = 1'b1, r_wr_hi_n = 1'b1, r_wr_lo_n = 1'b1, r_hold_n = 1'b1;
  logic [10:0] r_addr = '0;
  logic [15:0] r_wdata = '0;
  logic [15:0] r_rdata;
  logic [1:0]  r_rvalid;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dpr_byte_lane_ram i_dpr_byte_lane_ram (
    .clk(clk), .rst_n(rst_n),
    .l_sel_n(l_sel_n), .l_oe_n(l_oe_n), .l_wr_hi_n(l_wr_hi_n), .l_wr_lo_n(l_wr_lo_n),
    .l_hold_n(l_hold_n), .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata), .l_rvalid(l_rvalid),
    .r_sel_n(r_sel_n), .r_oe_n(r_oe_n), .r_wr_hi_n(r_wr_hi_n), .r_wr_lo_n(r_wr_lo_n),
    .r_hold_n(r_hold_n), .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata), .r_rvalid(r_rvalid)
  );

  // Active-high arguments: en, oe, write upper, write lower, busy.
  task automatic set_port(input bit right, input bit en, input bit oe, input bit wh,
                          input bit wl, input bit busy, input logic [10:0] a, input logic [15:0] d);
    if (right) begin
      r_sel_n = !en; r_oe_n = !oe; r_wr_hi_n = !wh; r_wr_lo_n = !wl; r_hold_n = !busy;
      r_addr = a; r_wdata = d;
    end else begin
      l_sel_n = !en; l_oe_n = !oe; l_wr_hi_n = !wh; l_wr_lo_n = !wl; l_hold_n = !busy;
      l_addr = a; l_wdata = d;
    end
  endtask

  task automatic idle();
    set_port(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, '0, '0);
    set_port(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, '0, '0);
  endtask

  // Inputs change at the falling edge; results are sampled at the next falling edge.
  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [17:0] act, input logic [17:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: valid/data actual %b/%h expected %b/%h",
               req, act[17:16], act[15:0], exp[17:16], exp[15:0]);
    end
  endtask

  task automatic read_l(input string req, input logic [10:0] a, input logic [15:0] exp);
    set_port(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, a, '0);
    step();
    chk(req, {l_rvalid, l_rdata}, {2'b11, exp});
    idle();
  endtask

  task automatic t_reset();
    chk("R1 reset left", {l_rvalid, l_rdata}, 18'h0);
    chk("R1 reset right", {r_rvalid, r_rdata}, 18'h0);
  endtask

  task automatic t_full_word();
    set_port(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 11'd5, 16'h1234);
    step();
    chk("R3 full write ignores oe", {l_rvalid, l_rdata}, 18'h0);
    read_l("R6 R8 full read", 11'd5, 16'h1234);
    set_port(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 11'd5, '0);
    step();
    chk("R6 no oe no strobe", {l_rvalid, l_rdata}, 18'h0);
    idle();
  endtask

  task automatic t_mixed();
    set_port(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 11'd5, 16'hAB99);
    step();
    chk("R4 write upper read lower", {l_rvalid, l_rdata}, {2'b01, 16'h0034});
    set_port(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 11'd5, 16'h77CD);
    step();
    chk("R4 write lower read upper", {l_rvalid, l_rdata}, {2'b10, 16'hAB00});
    idle();
    read_l("R4 mixed result", 11'd5, 16'hABCD);
  endtask

  task automatic t_no_oe();
    set_port(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 11'd5, 16'h00EE);
    step();
    chk("R5 single strobe no oe", {l_rvalid, l_rdata}, 18'h0);
    idle();
    read_l("R5 only lower written", 11'd5, 16'hABEE);
  endtask

  task automatic t_deselect();
    set_port(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 11'd5, 16'hFFFF);
    step();
    chk("R2 deselect no output", {l_rvalid, l_rdata}, 18'h0);
    idle();
    read_l("R2 deselect no write", 11'd5, 16'hABEE);
  endtask

  task automatic t_busy();
    set_port(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 11'd5, 16'h5555);
    step();
    idle();
    read_l("R7 busy blocks full write", 11'd5, 16'hABEE);
    set_port(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 11'd5, 16'h9900);
    step();
    chk("R7 busy read lane still works", {l_rvalid, l_rdata}, {2'b01, 16'h00EE});
    idle();
    read_l("R7 busy blocks byte write", 11'd5, 16'hABEE);
  endtask

  task automatic t_collide();
    set_port(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 11'd9, 16'h1111);
    set_port(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 11'd9, 16'h2222);
    step();
    idle();
    read_l("R9 right wins same byte", 11'd9, 16'h2222);
    set_port(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 11'd9, 16'h3300);
    set_port(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 11'd9, 16'h0044);
    step();
    idle();
    read_l("R9 different bytes both kept", 11'd9, 16'h3344);
  endtask

  task automatic t_flow();
    set_port(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 11'd9, 16'h5566);
    set_port(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 11'd9, '0);
    step();
    chk("R10 same-cycle read old data", {l_rvalid, l_rdata}, {2'b11, 16'h3344});
    chk("R3 right full write no output", {r_rvalid, r_rdata}, 18'h0);
    idle();
    read_l("R10 next-cycle read new data", 11'd9, 16'h5566);
  endtask

  task automatic t_dual_read();
    set_port(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 11'd9, '0);
    set_port(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 11'd9, '0);
    step();
    chk("R11 left dual read", {l_rvalid, l_rdata}, {2'b11, 16'h5566});
    chk("R11 right dual read", {r_rvalid, r_rdata}, {2'b11, 16'h5566});
    idle();
    set_port(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 11'd9, 16'hFF01);
    step();
    chk("R4 right write lower read upper", {r_rvalid, r_rdata}, {2'b10, 16'h5500});
    idle();
    read_l("R8 right byte write seen by left", 11'd9, 16'h5501);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_full_word();
    t_mixed();
    t_no_oe();
    t_deselect();
    t_busy();
    t_collide();
    t_flow();
    t_dual_read();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete (all requirements), actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule